// File: doc/BRIEF.md
# Packet-Driven Cabinet I/O Interface

This block links a combinational payload to a byte-serial packet link. It collects a fixed-length frame and extracts the sender's unit type, the information kind and the system-signal fields. It then picks one of three actions. It can leave the payload alone. It can refresh the payload inputs quietly. Or it can refresh them, wait a fixed number of cycles for the payload to settle, capture the payload outputs and send them back in a full reply.

The block holds two snapshots of the payload inputs. The current one is what the payload sees now. The previous one is what the payload saw before the latest accepted update. Both are exported, so a payload can detect rising edges on its control bits by comparing them. Every data frame is answered, either with a full reply or with a short acknowledge. Each answer carries this unit's own address and unit type, never the received ones.

Top module: `cab_io_if`

## Requirements
- R1: After reset, `tx_valid_o` is 0, `rx_ready_o` is 1, and both `pay_new_o` and `pay_old_o` are all zero.
- R2: A frame is 16 bytes, with byte 0 marked by `rx_sop_i`. The bytes are, in order:
  - 0: frame type (data 0x01, config 0x02, acknowledge 0x03, reply 0x04)
  - 1..6: address, most significant byte first
  - 7: source unit type
  - 8: info type
  - 9: system signals, with bits 3:0 = read_n, write_n, reset_n, busy_n
  - 10..11: bus address, high byte then low byte
  - 12: data
  - 13: flags in bits 4:0
  - 14..15: control word, high byte then low byte

  The payload vector is 49 bits: {signals[3:0], address[15:0], data[7:0], flags[4:0], control[15:0]}.
- R3: A data frame is accepted when source byte < 8 with `src_mask_i[source]` set, and info byte < 8 with `info_mask_i[info]` set. On acceptance, `pay_new_o` takes the frame's fields and `pay_old_o` takes the prior `pay_new_o`.
- R4: A data frame failing either mask test leaves both buffers unchanged and is answered with an acknowledge.
- R5: Config and acknowledge frames produce no reply and leave both buffers unchanged.
- R6: An accepted data frame whose `resp_mask_i[info]` is 0 is answered with an 8-byte acknowledge. Its bytes are: 0x03, `own_mac_i` with the most significant byte first, then `own_src_i`.
- R7: An accepted data frame whose `resp_mask_i[info]` is 1 is answered with a 16-byte reply. Its bytes are: 0x04, `own_mac_i`, `own_src_i`, the received info byte, then `pay_out_i` in the R2 layout. `pay_out_i` is sampled at the clock edge SETTLE_CYC cycles after the edge that updated `pay_new_o`.
- R8: A frame that is cut short by a new `rx_sop_i` is dropped without a reply, and the new frame starts. Bytes that arrive with no frame open are ignored.
- R9: `rx_ready_o` is 0 from the cycle after the last byte of a data frame until the last byte of its answer is transferred. `rx_ready_o` and `tx_valid_o` are never both 1.
- R10: While `tx_valid_o` is 1 and `tx_ready_i` is 0, `tx_data_o` and `tx_valid_o` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | async reset, active low |
| own_mac_i | input | 48 | this unit's address |
| own_src_i | input | 8 | this unit's type code |
| src_mask_i | input | 8 | accepted source types |
| info_mask_i | input | 8 | accepted info types |
| resp_mask_i | input | 8 | info types that get a full reply |
| rx_valid_i | input | 1 | receive byte valid |
| rx_sop_i | input | 1 | first byte of frame |
| rx_data_i | input | 8 | receive byte |
| rx_ready_o | output | 1 | receive byte accepted |
| tx_valid_o | output | 1 | transmit byte valid |
| tx_sop_o | output | 1 | first byte of answer |
| tx_data_o | output | 8 | transmit byte |
| tx_ready_i | input | 1 | transmit byte taken |
| pay_new_o | output | 49 | current payload inputs |
| pay_old_o | output | 49 | previous payload inputs |
| pay_out_i | input | 49 | payload outputs |

## Verification
The buffers change one edge after the last received byte, and `rx_ready_o` drops in the cycle between those two edges. The bench checks the ready level at the falling edge right after the last transfer, and checks the buffers only once the whole answer has gone out. The bench payload is a delay line SETTLE_CYC-1 stages deep. A capture made one edge too early therefore sees stale outputs, and the reply bytes show exactly which edge was sampled. Answers are gathered byte by byte at falling edges on every handshake. Their content and length are compared against a queue the bench builds from the frame it sent.

// File: rtl/cab_pkg.sv
package cab_pkg;
  localparam int PKT_BYTES = 16;
  localparam int ACK_BYTES = 8;
  localparam int FLD_W     = 49;
  localparam int FRAME_W   = PKT_BYTES * 8;

  localparam logic [7:0] PT_DATA = 8'h01;
  localparam logic [7:0] PT_CFG  = 8'h02;
  localparam logic [7:0] PT_ACK  = 8'h03;
  localparam logic [7:0] PT_RESP = 8'h04;

  typedef enum logic [1:0] {S_RX, S_SETTLE, S_TX} st_e;

  function automatic logic [FLD_W-1:0] get_fields(input logic [FRAME_W-1:0] f);
    return {f[75:72], f[87:80], f[95:88], f[103:96], f[108:104], f[119:112], f[127:120]};
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(
      input logic [7:0] pt, input logic [47:0] mac, input logic [7:0] src,
      input logic [7:0] info, input logic [FLD_W-1:0] fld);
    logic [FRAME_W-1:0] f;
    f = '0;
    f[7:0] = pt;
    for (int i = 0; i < 6; i++) f[(i+1)*8 +: 8] = mac[(5-i)*8 +: 8];
    f[63:56]   = src;
    f[71:64]   = info;
    f[79:72]   = {4'b0, fld[48:45]};
    f[87:80]   = fld[44:37];
    f[95:88]   = fld[36:29];
    f[103:96]  = fld[28:21];
    f[111:104] = {3'b0, fld[20:16]};
    f[119:112] = fld[15:8];
    f[127:120] = fld[7:0];
    return f;
  endfunction
endpackage

// File: rtl/cab_rx_parse.sv
module cab_rx_parse #(
  parameter int NB = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            sop_i,
  input  logic [7:0]      data_i,
  input  logic            ready_i,
  output logic [NB*8-1:0] pkt_o,
  output logic            done_o
);
  localparam int CW = $clog2(NB + 1);
  logic [CW-1:0] cnt_q;  // 0: no frame open
  wire xfer = valid_i && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pkt_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (xfer) begin
        if (sop_i) begin
          pkt_o[7:0] <= data_i;
          cnt_q      <= CW'(1);
        end else if (cnt_q != '0) begin
          pkt_o[{cnt_q, 3'b000} +: 8] <= data_i;
          if (cnt_q == CW'(NB - 1)) begin
            cnt_q  <= '0;
            done_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
      end
    end
  end

  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_after_byte_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(xfer && !sop_i));
endmodule

// File: rtl/cab_tx_ser.sv
module cab_tx_ser #(
  parameter int NB  = 16,
  parameter int NAK = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            full_i,
  input  logic [NB*8-1:0] frame_i,
  input  logic            ready_i,
  output logic            valid_o,
  output logic            sop_o,
  output logic [7:0]      data_o,
  output logic            last_o
);
  localparam int IW = $clog2(NB);
  logic [IW-1:0] idx_q;
  logic [IW-1:0] last_idx;

  assign last_idx = full_i ? IW'(NB - 1) : IW'(NAK - 1);
  assign valid_o  = en_i;
  assign sop_o    = en_i && (idx_q == '0);
  assign data_o   = frame_i[{idx_q, 3'b000} +: 8];
  assign last_o   = en_i && ready_i && (idx_q == last_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        idx_q <= '0;
    else if (!en_i)     idx_q <= '0;
    else if (ready_i)   idx_q <= last_o ? '0 : idx_q + IW'(1);
  end

  assert_tx_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/cab_io_if.sv
module cab_io_if #(
  parameter int SETTLE_CYC = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [47:0] own_mac_i,
  input  logic [7:0]  own_src_i,
  input  logic [7:0]  src_mask_i,
  input  logic [7:0]  info_mask_i,
  input  logic [7:0]  resp_mask_i,
  input  logic        rx_valid_i,
  input  logic        rx_sop_i,
  input  logic [7:0]  rx_data_i,
  output logic        rx_ready_o,
  output logic        tx_valid_o,
  output logic        tx_sop_o,
  output logic [7:0]  tx_data_o,
  input  logic        tx_ready_i,
  output logic [48:0] pay_new_o,
  output logic [48:0] pay_old_o,
  input  logic [48:0] pay_out_i
);
  import cab_pkg::*;
  localparam int CW = $clog2(SETTLE_CYC + 1);

  st_e                state_q;
  logic [CW-1:0]      cnt_q;
  logic [7:0]         info_q;
  logic               full_q;
  logic [FRAME_W-1:0] frame_q;
  logic [FRAME_W-1:0] rx_pkt;
  logic               rx_done;
  logic               tx_last;
  logic [7:0]         f_type, f_src, f_info;
  logic               accept, respond;

  assign rx_ready_o = (state_q == S_RX) && !rx_done;

  cab_rx_parse #(.NB(PKT_BYTES)) u_rx (
    .clk_i, .rst_ni, .valid_i(rx_valid_i), .sop_i(rx_sop_i), .data_i(rx_data_i),
    .ready_i(rx_ready_o), .pkt_o(rx_pkt), .done_o(rx_done));

  cab_tx_ser #(.NB(PKT_BYTES), .NAK(ACK_BYTES)) u_tx (
    .clk_i, .rst_ni, .en_i(state_q == S_TX), .full_i(full_q), .frame_i(frame_q),
    .ready_i(tx_ready_i), .valid_o(tx_valid_o), .sop_o(tx_sop_o), .data_o(tx_data_o),
    .last_o(tx_last));

  assign f_type  = rx_pkt[7:0];
  assign f_src   = rx_pkt[63:56];
  assign f_info  = rx_pkt[71:64];
  assign accept  = (f_src < 8'd8) && src_mask_i[f_src[2:0]] &&
                   (f_info < 8'd8) && info_mask_i[f_info[2:0]];
  assign respond = accept && resp_mask_i[f_info[2:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_RX;
      cnt_q     <= '0;
      info_q    <= '0;
      full_q    <= 1'b0;
      frame_q   <= '0;
      pay_new_o <= '0;
      pay_old_o <= '0;
    end else begin
      unique case (state_q)
        S_RX: if (rx_done && f_type == PT_DATA) begin
          info_q <= f_info;
          if (accept) begin
            pay_old_o <= pay_new_o;
            pay_new_o <= get_fields(rx_pkt);
          end
          if (respond) begin
            state_q <= S_SETTLE;
            cnt_q   <= CW'(SETTLE_CYC - 1);
          end else begin
            frame_q <= build_frame(PT_ACK, own_mac_i, own_src_i, 8'h00, '0);
            full_q  <= 1'b0;
            state_q <= S_TX;
          end
        end
        S_SETTLE: if (cnt_q == '0) begin
          frame_q <= build_frame(PT_RESP, own_mac_i, own_src_i, info_q, pay_out_i);
          full_q  <= 1'b1;
          state_q <= S_TX;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
        S_TX: if (tx_last) state_q <= S_RX;
        default: state_q <= S_RX;
      endcase
    end
  end

  assert_no_rx_during_tx_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_ready_o && tx_valid_o));
  assert_old_tracks_new_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pay_old_o) |-> (pay_old_o == $past(pay_new_o)));
  assert_buffers_only_on_frame_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pay_new_o) |-> $past(rx_done));
  assert_sop_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_sop_o |-> tx_valid_o);
endmodule

// File: tb/tb_cab_io_if.sv
module tb_cab_io_if;
  localparam int SETTLE = 4;
  localparam int DLY = SETTLE - 1;
  localparam logic [47:0] MAC = 48'h0A1B2C3D4E5F;
  localparam logic [7:0]  OWN = 8'h07;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic rx_valid_i = 1'b0, rx_sop_i = 1'b0, tx_ready_i = 1'b1;
  logic [7:0] rx_data_i = '0;
  logic rx_ready_o, tx_valid_o, tx_sop_o;
  logic [7:0] tx_data_o;
  logic [48:0] pay_new_o, pay_old_o, pay_out_i;
  logic [48:0] pipe [DLY];

  int checks = 0, fails = 0;
  logic [48:0] m_new = '0, m_old = '0;
  logic [7:0] got[$];
  logic [7:0] exp_q[$];
  logic [7:0] prev_data;
  logic prev_stall = 1'b0;

  always #5 clk_i = ~clk_i;

  cab_io_if #(.SETTLE_CYC(SETTLE)) dut (
    .clk_i, .rst_ni, .own_mac_i(MAC), .own_src_i(OWN), .src_mask_i(8'b0000_0110),
    .info_mask_i(8'b0000_0110), .resp_mask_i(8'b0000_0010), .rx_valid_i, .rx_sop_i,
    .rx_data_i, .rx_ready_o, .tx_valid_o, .tx_sop_o, .tx_data_o, .tx_ready_i,
    .pay_new_o, .pay_old_o, .pay_out_i);

  // bench payload: output lags inputs by DLY cycles
  function automatic logic [48:0] pf(input logic [48:0] x);
    return ~x ^ 49'h0_1234_5678_9ABC;
  endfunction
  always_ff @(posedge clk_i) begin
    pipe[0] <= pf(pay_new_o);
    for (int k = 1; k < DLY; k++) pipe[k] <= pipe[k-1];
  end
  assign pay_out_i = pipe[DLY-1];

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // monitor: collect answers, check hold under stall
  always @(negedge clk_i) begin
    if (prev_stall) check(tx_valid_o && tx_data_o == prev_data, "R10", tx_data_o, prev_data);
    prev_stall = tx_valid_o && !tx_ready_i;
    prev_data  = tx_data_o;
    if (tx_valid_o && tx_ready_i) got.push_back(tx_data_o);
    if (rx_ready_o && tx_valid_o) check(0, "R9", 1, 0);
  end

  function automatic logic [127:0] mk(input logic [7:0] pt, input logic [7:0] src,
      input logic [7:0] info, input logic [48:0] fld);
    logic [127:0] p;
    p = {8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'hEE, 8'hFF, 80'h0};
    p[7:0] = pt; p[63:56] = src; p[71:64] = info;
    p[79:72] = {4'h0, fld[48:45]}; p[87:80] = fld[44:37]; p[95:88] = fld[36:29];
    p[103:96] = fld[28:21]; p[111:104] = {3'h0, fld[20:16]};
    p[119:112] = fld[15:8]; p[127:120] = fld[7:0];
    return p;
  endfunction

  task automatic send(input logic [127:0] p, input int n, input bit use_sop);
    for (int i = 0; i < n; i++) begin
      rx_valid_i = 1'b1; rx_sop_i = use_sop && (i == 0); rx_data_i = p[i*8 +: 8];
      while (!rx_ready_o) @(negedge clk_i);
      @(negedge clk_i);
    end
    rx_valid_i = 1'b0; rx_sop_i = 1'b0;
  endtask

  task automatic exp_head(input logic [7:0] pt);
    exp_q.delete();
    exp_q.push_back(pt);
    for (int i = 5; i >= 0; i--) exp_q.push_back(MAC[i*8 +: 8]);
    exp_q.push_back(OWN);
  endtask

  task automatic exp_resp(input logic [7:0] info, input logic [48:0] o);
    exp_head(8'h04);
    exp_q.push_back(info); exp_q.push_back({4'h0, o[48:45]});
    exp_q.push_back(o[44:37]); exp_q.push_back(o[36:29]); exp_q.push_back(o[28:21]);
    exp_q.push_back({3'h0, o[20:16]}); exp_q.push_back(o[15:8]); exp_q.push_back(o[7:0]);
  endtask

  task automatic wait_answer(input string req);
    int t = 0;
    while (got.size() < exp_q.size() && t < 300) begin @(negedge clk_i); t++; end
    repeat (30) @(negedge clk_i);
    check(got.size() == exp_q.size(), req, got.size(), exp_q.size());
    for (int i = 0; i < got.size() && i < exp_q.size(); i++)
      check(got[i] == exp_q[i], req, got[i], exp_q[i]);
    got.delete();
  endtask

  task automatic check_bufs(input string req);
    check(pay_new_o == m_new, req, pay_new_o, m_new);
    check(pay_old_o == m_old, req, pay_old_o, m_old);
  endtask

  initial begin
    #2_000_000;
    check(0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [48:0] fa, fb, fc;
    fa = 49'h1_2345_6789_ABCD; fb = 49'h0_F0E1_D2C3_B4A5; fc = 49'h1_8001_4002_2003;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(tx_valid_o == 0, "R1", tx_valid_o, 0);
    check(rx_ready_o == 1, "R1", rx_ready_o, 1);
    check_bufs("R1");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R6/R3 silent update, ack
    send(mk(8'h01, 8'h01, 8'h02, fa), 16, 1);
    m_old = m_new; m_new = fa;
    exp_head(8'h03); wait_answer("R6");
    check_bufs("R3");

    // R7/R9 full reply after settle
    send(mk(8'h01, 8'h02, 8'h01, fb), 16, 1);
    check(rx_ready_o == 0, "R9", rx_ready_o, 0);
    m_old = m_new; m_new = fb;
    exp_resp(8'h01, pf(fb)); wait_answer("R7");
    check_bufs("R3");

    // R4 source rejected, then info rejected
    send(mk(8'h01, 8'h05, 8'h01, fc), 16, 1);
    exp_head(8'h03); wait_answer("R4");
    check_bufs("R4");
    send(mk(8'h01, 8'h01, 8'h09, fc), 16, 1);
    exp_head(8'h03); wait_answer("R4");
    check_bufs("R4");

    // R5 config and acknowledge frames
    send(mk(8'h02, 8'h01, 8'h01, fc), 16, 1);
    exp_q.delete(); wait_answer("R5");
    send(mk(8'h03, 8'h01, 8'h02, fc), 16, 1);
    exp_q.delete(); wait_answer("R5");
    check_bufs("R5");

    // R8 truncated frame then full frame; stray bytes
    send(mk(8'h01, 8'h01, 8'h02, fa), 10, 1);
    send(mk(8'h01, 8'h01, 8'h01, fc), 16, 1);
    m_old = m_new; m_new = fc;
    exp_resp(8'h01, pf(fc)); wait_answer("R8");
    check_bufs("R8");
    send(mk(8'h01, 8'h01, 8'h01, fa), 16, 0);
    exp_q.delete(); wait_answer("R8");
    check_bufs("R8");

    // R10 reply under back-pressure
    fork
      send(mk(8'h01, 8'h02, 8'h01, fa), 16, 1);
      begin
        for (int i = 0; i < 60; i++) begin @(negedge clk_i); tx_ready_i = (i % 3 == 0); end
        tx_ready_i = 1'b1;
      end
    join
    m_old = m_new; m_new = fa;
    exp_resp(8'h01, pf(fa)); wait_answer("R10");
    check_bufs("R3");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule